// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Datapath

This block executes a small load/store instruction subset in one clock per instruction: register-register arithmetic and logic, immediate add and OR, word load, word store and branch-if-equal. It contains the program counter with its next-address logic, the instruction store, a 32-entry register file with two read ports and one write port, an immediate extender, an ALU, a separate data store, and the multiplexers that pick the second ALU operand, the destination register and the write-back value. A combinational decoder turns the opcode and function fields into the steering signals for each instruction.

The instruction and data stores are separate arrays, so the fetch at the PC and the data access at the ALU address take place in the same cycle. Both stores are filled through a word-wide load port while reset is held. The port list also carries the fetched instruction, the register write-back (enable, index and value) and the data-store write (enable, byte address and value), so every architectural effect of an instruction can be seen at the boundary in the cycle it executes.

Top module: `sc_datapath`

## Requirements
- R1: While `rst` is 1 at a rising edge the PC becomes 0 at that edge; during reset `wb_en` and `st_en` are 0.
- R2: The instruction `instr` is the word at PC bits [IAW+1:2]; a non-branch instruction moves the PC to PC+4 at the next edge. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0].
- R3: Opcode 0 with function 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt to rd (`wb_en`=1, `wb_addr`=rd).
- R4: Opcode 0 with function 0x2A writes 1 to rd when rs is less than rt as signed numbers, else 0.
- R5: Opcode 0x0D writes rs OR the zero-extended immediate to rt.
- R6: Opcode 0x08 writes rs plus the sign-extended immediate to rt.
- R7: Opcode 0x23 writes to rt the data word at byte address rs + sign-extended immediate, indexed by address bits [DAW+1:2].
- R8: Opcode 0x2B stores rt at byte address rs + sign-extended immediate (`st_en`=1) and does not write the register file; a later load from that address returns the stored word.
- R9: Opcode 0x04 compares rs and rt; when equal the next PC is PC+4 plus the sign-extended immediate shifted left by two, else PC+4. It writes neither registers nor data.
- R10: Register 0 reads as 0; a write addressed to register 0 has no effect.
- R11: Any other opcode, or opcode 0 with any other function, writes nothing, stores nothing and advances the PC by 4.
- R12: With `rst`=1 and `load_en`=1, `load_data` is written at word index `load_addr` into the data store when `load_dmem`=1, else into the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Store load strobe, acts only in reset |
| load_dmem | input | 1 | 1 selects data store, 0 instruction store |
| load_addr | input | LAW | Word index for the load |
| load_data | input | 32 | Word to load |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction fetched at `pc` |
| wb_en | output | 1 | Decoded register write enable |
| wb_addr | output | 5 | Destination register index |
| wb_data | output | 32 | Write-back value |
| st_en | output | 1 | Data store write enable |
| st_addr | output | 32 | Store byte address (ALU result) |
| st_data | output | 32 | Word being stored |

## Verification
Every result of an instruction is due in the same cycle as its fetch: `instr`, the write-back fields and the store fields are combinational from the current PC and state, while the PC, the register file and the data store change at the following rising edge. The bench keeps a behavioural model of the PC, registers and data store, and at each falling edge compares the outputs with the model's expectation for the current instruction before it advances the model by one instruction. Effects that land at the edge (register contents, stored words, a taken branch) are therefore checked one cycle later, through the operands, load data or PC of the following instruction.

// File: rtl/sc_datapath.sv
module sc_datapath #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic           load_dmem,
  input  logic [LAW-1:0] load_addr,
  input  logic [31:0]    load_data,
  output logic [31:0]    pc,
  output logic [31:0]    instr,
  output logic           wb_en,
  output logic [4:0]     wb_addr,
  output logic [31:0]    wb_data,
  output logic           st_en,
  output logic [31:0]    st_addr,
  output logic [31:0]    st_data
);

  localparam logic [2:0] ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2,
                         ALU_OR  = 3'd3, ALU_SLT = 3'd4;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [32];

  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  logic        dst_rd, src_imm, ext_sign, mem_to_reg, reg_wr, mem_wr, is_beq;
  logic [2:0]  alu_ctl;
  logic [31:0] bus_a, bus_b, ext_imm, alu_b, alu_y, pc_inc, pc_br;
  logic        zero;
  logic        unused_bits;

  assign instr = imem[pc[IAW+1:2]];
  assign op  = instr[31:26];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign fn  = instr[5:0];
  assign imm = instr[15:0];
  assign unused_bits = ^instr[10:6];

  always_comb begin
    dst_rd = 1'b0; src_imm = 1'b0; ext_sign = 1'b1; mem_to_reg = 1'b0;
    reg_wr = 1'b0; mem_wr = 1'b0; is_beq = 1'b0; alu_ctl = ALU_ADD;
    case (op)
      6'h00: begin
        dst_rd = 1'b1;
        reg_wr = 1'b1;
        case (fn)
          6'h20: alu_ctl = ALU_ADD;
          6'h22: alu_ctl = ALU_SUB;
          6'h24: alu_ctl = ALU_AND;
          6'h25: alu_ctl = ALU_OR;
          6'h2A: alu_ctl = ALU_SLT;
          default: reg_wr = 1'b0;
        endcase
      end
      6'h08: begin src_imm = 1'b1; reg_wr = 1'b1; end
      6'h0D: begin src_imm = 1'b1; ext_sign = 1'b0; alu_ctl = ALU_OR; reg_wr = 1'b1; end
      6'h23: begin src_imm = 1'b1; mem_to_reg = 1'b1; reg_wr = 1'b1; end
      6'h2B: begin src_imm = 1'b1; mem_wr = 1'b1; end
      6'h04: begin alu_ctl = ALU_SUB; is_beq = 1'b1; end
      default: ;
    endcase
  end

  assign bus_a   = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign bus_b   = (rt == 5'd0) ? 32'd0 : regs[rt];
  assign ext_imm = ext_sign ? {{16{imm[15]}}, imm} : {16'd0, imm};
  assign alu_b   = src_imm ? ext_imm : bus_b;

  always_comb begin
    case (alu_ctl)
      ALU_SUB: alu_y = bus_a - alu_b;
      ALU_AND: alu_y = bus_a & alu_b;
      ALU_OR:  alu_y = bus_a | alu_b;
      ALU_SLT: alu_y = {31'd0, $signed(bus_a) < $signed(alu_b)};
      default: alu_y = bus_a + alu_b;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign wb_en   = reg_wr & ~rst;
  assign wb_addr = dst_rd ? rd : rt;
  assign wb_data = mem_to_reg ? dmem[alu_y[DAW+1:2]] : alu_y;
  assign st_en   = mem_wr & ~rst;
  assign st_addr = alu_y;
  assign st_data = bus_b;

  assign pc_inc = pc + 32'd4;
  assign pc_br  = pc_inc + {{14{imm[15]}}, imm, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else if (is_beq && zero) pc <= pc_br;
    else pc <= pc_inc;
  end

  always_ff @(posedge clk) begin
    if (wb_en && wb_addr != 5'd0) regs[wb_addr] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (rst && load_en && !load_dmem) imem[load_addr[IAW-1:0]] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rst && load_en && load_dmem) dmem[load_addr[DAW-1:0]] <= load_data;
    else if (st_en) dmem[alu_y[DAW+1:2]] <= bus_b;
  end

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == 32'd0); // R1
  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !wb_en && !st_en); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !is_beq |=> pc == $past(pc) + 32'd4); // R2
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en); // R8
  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
    $past(st_en) |-> dmem[$past(alu_y[DAW+1:2])] == $past(bus_b)); // R8
  AST_REG_LANDS: assert property (@(posedge clk) disable iff (rst)
    $past(wb_en) && $past(wb_addr) != 5'd0 |-> regs[$past(wb_addr)] == $past(wb_data)); // R3
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    rs == 5'd0 && !src_imm && alu_ctl == ALU_ADD && reg_wr |-> wb_data == bus_b); // R10
  AST_BEQ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    is_beq |-> !wb_en && !st_en); // R9

endmodule

// File: tb/sc_datapath_bench.sv
module sc_datapath_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic        load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc, instr, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_i [64];
  logic [31:0] m_d [64];
  logic [31:0] m_r [32];
  logic [31:0] m_pc;

  always #10 clk = ~clk;

  sc_datapath u_sc_datapath (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .pc(pc), .instr(instr),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data));

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (pc %h)", tag, what, act, exp, m_pc);
    end
  endtask

  function automatic logic [31:0] rt_ins(input int s, input int t, input int d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction

  function automatic logic [31:0] it_ins(input logic [5:0] o, input int s, input int t, input logic [15:0] i);
    return {o, 5'(s), 5'(t), i};
  endfunction

  task automatic load_word(input bit to_d, input int idx, input logic [31:0] w);
    @(negedge clk);
    load_en = 1'b1; load_dmem = to_d; load_addr = 6'(idx); load_data = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic step_model;
    logic [5:0] op, fn;
    int s, t, d;
    logic [31:0] a, b, sx, zx, ad, npc, e_wd;
    logic e_wb, e_st;
    int e_wa;
    string tag;
    logic [31:0] ins;
    ins = m_i[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    s = int'(ins[25:21]); t = int'(ins[20:16]); d = int'(ins[15:11]);
    a = (s == 0) ? 32'd0 : m_r[s];
    b = (t == 0) ? 32'd0 : m_r[t];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'd0, ins[15:0]};
    ad = a + sx;
    npc = m_pc + 32'd4;
    e_wb = 1'b0; e_st = 1'b0; e_wa = 0; e_wd = 32'd0; tag = "R11";
    case (op)
      6'h00: begin
        e_wa = d; e_wb = 1'b1; tag = "R3";
        case (fn)
          6'h20: e_wd = a + b;
          6'h22: e_wd = a - b;
          6'h24: e_wd = a & b;
          6'h25: e_wd = a | b;
          6'h2A: begin e_wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
          default: begin e_wb = 1'b0; tag = "R11"; end
        endcase
        if (e_wb && (s == 0 || d == 0)) tag = "R10";
      end
      6'h08: begin e_wb = 1'b1; e_wa = t; e_wd = ad; tag = "R6"; end
      6'h0D: begin e_wb = 1'b1; e_wa = t; e_wd = a | zx; tag = "R5"; end
      6'h23: begin e_wb = 1'b1; e_wa = t; e_wd = m_d[ad[7:2]]; tag = "R7"; end
      6'h2B: begin e_st = 1'b1; tag = "R8"; end
      6'h04: begin tag = "R9"; if (a == b) npc = npc + {sx[29:0], 2'b00}; end
      default: ;
    endcase
    check("R2", "instr", instr, ins);
    check("R2", "pc", pc, m_pc);
    check(tag, "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
    check(tag, "st_en", {31'd0, st_en}, {31'd0, e_st});
    if (e_wb) begin
      check(tag, "wb_addr", {27'd0, wb_addr}, 32'(e_wa));
      check(tag, "wb_data", wb_data, e_wd);
    end
    if (e_st) begin
      check(tag, "st_addr", st_addr, ad);
      check(tag, "st_data", st_data, b);
    end
    if (e_wb && e_wa != 0) m_r[e_wa] = e_wd;
    if (e_st) m_d[ad[7:2]] = b;
    m_pc = npc;
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin m_i[k] = 32'd0; m_d[k] = 32'd0; end
    for (int k = 0; k < 32; k++) m_r[k] = 32'd0;
    m_i[0]  = it_ins(6'h08, 0, 1, 16'd5);
    m_i[1]  = it_ins(6'h08, 0, 2, 16'hFFFD);
    m_i[2]  = rt_ins(1, 2, 3, 6'h20);
    m_i[3]  = rt_ins(2, 1, 4, 6'h22);
    m_i[4]  = rt_ins(1, 2, 5, 6'h24);
    m_i[5]  = rt_ins(1, 2, 6, 6'h25);
    m_i[6]  = rt_ins(2, 1, 7, 6'h2A);
    m_i[7]  = rt_ins(1, 2, 8, 6'h2A);
    m_i[8]  = it_ins(6'h0D, 0, 9, 16'h8001);
    m_i[9]  = it_ins(6'h23, 0, 10, 16'd12);
    m_i[10] = it_ins(6'h23, 0, 11, 16'd0);
    m_i[11] = it_ins(6'h2B, 0, 1, 16'd8);
    m_i[12] = it_ins(6'h23, 0, 12, 16'd8);
    m_i[13] = rt_ins(1, 1, 0, 6'h20);
    m_i[14] = rt_ins(0, 1, 13, 6'h20);
    m_i[15] = 32'hFC00_0000;
    m_i[16] = rt_ins(1, 2, 14, 6'h3F);
    m_i[17] = it_ins(6'h04, 1, 2, 16'd5);
    m_i[18] = it_ins(6'h04, 1, 12, 16'd2);
    m_i[19] = it_ins(6'h08, 0, 14, 16'd99);
    m_i[20] = it_ins(6'h08, 0, 14, 16'd98);
    m_i[21] = it_ins(6'h08, 0, 15, 16'd8);
    m_i[22] = it_ins(6'h23, 15, 16, 16'd4);
    m_i[23] = it_ins(6'h0D, 2, 17, 16'h00F0);
    m_i[24] = it_ins(6'h04, 0, 0, 16'hFFFF);
    m_d[0] = 32'h1122_3344;
    m_d[3] = 32'hFFFF_FFF0;

    @(negedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pc, 32'd0);
    check("R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
    check("R1", "st_en in reset", {31'd0, st_en}, 32'd0);
    for (int k = 0; k < 25; k++) load_word(1'b0, k, m_i[k]);
    load_word(1'b1, 0, m_d[0]);
    load_word(1'b1, 3, m_d[3]);
    check("R12", "instr after load", instr, m_i[0]);
    check("R1", "pc held in reset", pc, 32'd0);
    check("R1", "wb_en quiet", {31'd0, wb_en}, 32'd0);

    m_pc = 32'd0;
    rst = 1'b0;
    #1;
    for (int c = 0; c < 40; c++) begin
      step_model();
      @(negedge clk);
      #1;
    end
    check("R9", "loop pc", pc, 32'd96);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule